// File: doc/BRIEF.md
# Pointer-Addressed Buffer Memory Port

This block gives a host processor access to a 2048-byte buffer memory through a window of four byte-wide registers. There is no direct address map. The host first sets an 11-bit pointer, split across an upper and a lower pointer register, and then moves bytes through a single data register. Reads return a byte that was fetched ahead of time into the data register, so every host access completes in its strobe cycle with no wait states and no ready handshake. A write first lands in the data register and is then committed to memory at the pointer.

Two control bits share the upper pointer register. The step bit selects sequential mode, in which the pointer advances after each data transfer, or fixed mode, in which the pointer stays put for random access. The direction bit selects whether a sequential stream reads from or writes to the buffer.

A small controller sequences the memory side. Its states are IDLE, FETCH and STORE. The transitions are:
- IDLE→FETCH on a lower-pointer write, or on a data read with the step bit set in read direction.
- IDLE→STORE on a data write.
- FETCH→IDLE and STORE→IDLE, each after one cycle.

Top module: `buf_port`

## Requirements
- R1: After reset the pointer is 0x000, both control bits are 0, and the data register reads 0x00.
- R2: Register offsets are 0 for the upper pointer, 1 for the lower pointer, 2 for data and 3 unused, which reads 0x00. The upper register reads back as bit 7 = step enable, bit 6 = direction (1 = read), bits 5:3 = 0 and bits 2:0 = pointer[10:8]. The lower register reads back pointer[7:0]. Read data is driven combinationally in the strobe cycle.
- R3: A write to the lower pointer loads the memory byte at the new pointer into the data register. The byte is readable from the second cycle after the strobe.
- R4: With the step bit clear, data reads change neither the data register nor the pointer. A write to the upper pointer never starts a fetch.
- R5: A data write loads the data register at once and stores that byte at the pointer in the following cycle.
- R6: With the step bit set, the pointer advances by one after each data write, and after each data read in read direction. In the read case the next byte is then fetched. The pointer wraps from 0x7FF to 0x000.
- R7: FETCH and STORE each last exactly one cycle and never overlap. The host leaves at least one idle cycle between accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid in the strobe cycle |

## Verification
The assertions check on every cycle the following:
- a lower-pointer write is always followed by a fetch, and an upper-pointer write never is;
- fixed-mode data reads leave the data register and pointer unchanged;
- each data write is followed by a store of exactly that byte;
- every pointer step adds one modulo 2048;
- FETCH and STORE are mutually exclusive.

Only the bench's scenarios show that the right bytes come back. This covers a sequential fill read back as a stream, random fixed-mode reads, a byte written at 0x7FF followed by one at 0x000 after the wrap, and the data register keeping its byte across an upper-pointer write.

// File: rtl/buf_port_pkg.sv
package buf_port_pkg;
    localparam logic [1:0] REG_PHI  = 2'd0;
    localparam logic [1:0] REG_PLO  = 2'd1;
    localparam logic [1:0] REG_DATA = 2'd2;
    localparam logic [1:0] REG_NONE = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_STORE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/buf_port_ram.sv
module buf_port_ram #(
    parameter int DEPTH = 2048,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/buf_port_ctrl.sv
module buf_port_ctrl
    import buf_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_sel,
    input  logic       host_wr,
    input  logic [1:0] host_addr,
    input  logic       step_en,
    input  logic       dir_rd,
    output seq_state_t state,
    output logic       fetch_ld,
    output logic       ram_we,
    output logic       ptr_inc
);
    seq_state_t nxt;
    logic wr_lo, wr_dat, rd_dat;

    assign wr_lo  = host_sel &&  host_wr && host_addr == REG_PLO;
    assign wr_dat = host_sel &&  host_wr && host_addr == REG_DATA;
    assign rd_dat = host_sel && !host_wr && host_addr == REG_DATA;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt      = state;
        fetch_ld = 1'b0;
        ram_we   = 1'b0;
        ptr_inc  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (wr_lo) begin
                    nxt = ST_FETCH;
                end else if (rd_dat && step_en && dir_rd) begin
                    ptr_inc = 1'b1;
                    nxt     = ST_FETCH;
                end else if (wr_dat) begin
                    nxt = ST_STORE;
                end
            end
            ST_FETCH: begin
                fetch_ld = 1'b1;
                nxt      = ST_IDLE;
            end
            ST_STORE: begin
                ram_we  = 1'b1;
                ptr_inc = step_en;
                nxt     = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/buf_port_regs.sv
module buf_port_regs
    import buf_port_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 8,
    localparam int HI_BITS = AW - 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_sel,
    input  logic          host_wr,
    input  logic [1:0]    host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic          fetch_ld,
    input  logic          ptr_inc,
    input  logic [DW-1:0] ram_rdata,
    output logic [AW-1:0] ptr,
    output logic [DW-1:0] data_q,
    output logic          step_en,
    output logic          dir_rd,
    output logic [DW-1:0] host_rdata
);
    logic wr_hi, wr_lo, wr_dat;

    assign wr_hi  = host_sel && host_wr && host_addr == REG_PHI;
    assign wr_lo  = host_sel && host_wr && host_addr == REG_PLO;
    assign wr_dat = host_sel && host_wr && host_addr == REG_DATA;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr     <= '0;
            step_en <= 1'b0;
            dir_rd  <= 1'b0;
        end else if (wr_hi) begin
            step_en          <= host_wdata[7];
            dir_rd           <= host_wdata[6];
            ptr[AW-1:8]      <= host_wdata[HI_BITS-1:0];
        end else if (wr_lo) begin
            ptr[7:0] <= host_wdata;
        end else if (ptr_inc) begin
            ptr <= ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        data_q <= '0;
        else if (wr_dat)   data_q <= host_wdata;
        else if (fetch_ld) data_q <= ram_rdata;
    end

    always_comb begin
        unique case (host_addr)
            REG_PHI:  host_rdata = {step_en, dir_rd, {(6-HI_BITS){1'b0}}, ptr[AW-1:8]};
            REG_PLO:  host_rdata = ptr[7:0];
            REG_DATA: host_rdata = data_q;
            default:  host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/buf_port.sv
module buf_port
    import buf_port_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH),
    localparam int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_sel,
    input  logic          host_wr,
    input  logic [1:0]    host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata
);
    seq_state_t    state;
    logic          fetch_ld, ram_we, ptr_inc, step_en, dir_rd;
    logic [AW-1:0] ptr;
    logic [DW-1:0] data_q, ram_rdata;

    buf_port_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .step_en(step_en), .dir_rd(dir_rd),
        .state(state), .fetch_ld(fetch_ld), .ram_we(ram_we), .ptr_inc(ptr_inc)
    );

    buf_port_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .fetch_ld(fetch_ld),
        .ptr_inc(ptr_inc), .ram_rdata(ram_rdata), .ptr(ptr), .data_q(data_q),
        .step_en(step_en), .dir_rd(dir_rd), .host_rdata(host_rdata)
    );

    buf_port_ram #(.DEPTH(DEPTH), .WIDTH(DW)) u_ram (
        .clk(clk), .we(ram_we), .addr(ptr), .wdata(data_q), .rdata(ram_rdata)
    );
endmodule

// File: rtl/buf_port_chk.sv
module buf_port_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_sel,
    input logic          host_wr,
    input logic [1:0]    host_addr,
    input logic [7:0]    host_wdata,
    input logic [AW-1:0] ptr,
    input logic [7:0]    data_q,
    input logic          fetch_ld,
    input logic          ram_we,
    input logic          ptr_inc,
    input logic          step_en
);
    logic w_hi, w_lo, w_dat, r_dat;
    assign w_hi  = host_sel &&  host_wr && host_addr == 2'd0;
    assign w_lo  = host_sel &&  host_wr && host_addr == 2'd1;
    assign w_dat = host_sel &&  host_wr && host_addr == 2'd2;
    assign r_dat = host_sel && !host_wr && host_addr == 2'd2;

    p_lo_prefetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        w_lo |=> fetch_ld);

    p_fixed_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_dat && !step_en) |=> ($stable(data_q) && $stable(ptr)));

    p_hi_nofetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        w_hi |=> !fetch_ld);

    p_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        w_dat |=> (ram_we && data_q == $past(host_wdata)));

    p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_inc |=> ptr == $past(ptr) + 1'b1);

    p_seq_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_ld && ram_we));
endmodule

bind buf_port buf_port_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_buf_port.sv
module sim_buf_port;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0;
    logic       host_wr = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #(CLK_NS/2) clk = ~clk;

    buf_port u0 (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    task automatic access(input logic w, input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        host_sel = 1'b1; host_wr = w; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        access(1'b1, a, d);
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
        item_t it;
        it.exp = e; it.tag = t;
        sb.push_back(it);
        access(1'b0, a, 8'd0);
    endtask

    // monitor: compare read data mid-cycle against the scoreboard
    always @(negedge clk) begin
        if (rst_n && host_sel && !host_wr) begin
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL unexpected read: actual=%h expected=none", host_rdata);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (host_rdata !== it.exp) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, host_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_NS * 200000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values, R2 unused offset
        rd(2'd0, 8'h00, "R1 ptr hi");
        rd(2'd1, 8'h00, "R1 ptr lo");
        rd(2'd2, 8'h00, "R1 data");
        rd(2'd3, 8'h00, "R2 unused offset");

        // R6 sequential fill at 0x010, write direction
        wr(2'd0, 8'h80);
        wr(2'd1, 8'h10);
        for (int i = 0; i < 16; i++) wr(2'd2, 8'h30 + 8'(i));
        rd(2'd1, 8'h20, "R6 ptr after fill");
        rd(2'd0, 8'h80, "R2 hi readback");

        // R3/R6 stream back in read direction
        wr(2'd0, 8'hC0);
        wr(2'd1, 8'h10);
        for (int i = 0; i < 16; i++)
            rd(2'd2, 8'h30 + 8'(i), (i == 0) ? "R3 first prefetch" : "R6 stream byte");
        rd(2'd1, 8'h20, "R6 ptr after stream");

        // R5 fixed-mode write at 0x123
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h23);
        wr(2'd2, 8'hA5);
        rd(2'd2, 8'hA5, "R5 staged byte");
        rd(2'd1, 8'h23, "R5 ptr lo fixed");
        rd(2'd0, 8'h01, "R5 ptr hi fixed");

        // R4 fixed-mode random read
        wr(2'd0, 8'h40);
        wr(2'd1, 8'h15);
        rd(2'd2, 8'h35, "R3 random prefetch");
        rd(2'd2, 8'h35, "R4 repeat read");
        rd(2'd1, 8'h15, "R4 ptr unchanged");

        // R5 committed byte comes back
        wr(2'd0, 8'h41);
        wr(2'd1, 8'h23);
        rd(2'd2, 8'hA5, "R5 committed byte");

        // R4 upper pointer write fetches nothing
        wr(2'd0, 8'h40);
        rd(2'd2, 8'hA5, "R4 hi write no fetch");
        rd(2'd0, 8'h40, "R2 hi readback fixed read");

        // R6 wraparound
        wr(2'd0, 8'h87);
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'h11);
        rd(2'd0, 8'h80, "R6 wrap hi");
        rd(2'd1, 8'h00, "R6 wrap lo");
        wr(2'd2, 8'h22);
        wr(2'd0, 8'hC7);
        wr(2'd1, 8'hFF);
        rd(2'd2, 8'h11, "R6 byte at 0x7FF");
        rd(2'd2, 8'h22, "R6 byte at 0x000 after wrap");
        rd(2'd0, 8'hC0, "R6 hi after read wrap");
        rd(2'd1, 8'h01, "R6 lo after read wrap");

        repeat (3) @(posedge clk);
        if (sb.size() != 0) begin
            total++; bad++;
            $display("FAIL R7 pending reads: actual=%0d expected=0", sb.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule